// File: doc/BRIEF.md
# Phase-Encoded Tape Write Formatter

This block turns host data words into a stream of phase-encoded half-cells for a nine-track tape write channel. Before a record is written, the frame counter is loaded with the negated character count. A pulse from the drive then reports that the tape is up to speed, and the block writes the record in this order: a leading sync field, the data characters taken from host words, and a trailing sync field. Each data character gets an odd vertical parity bit on the ninth track. Every character leaves the block as two consecutive half-cells on all nine tracks.

The host offers words on a valid/ready handshake. The block asks for a word only when it is about to start that word's first character. It uses the low byte first and then the high byte. The frame counter counts up once per data character. When it reaches zero, the data phase ends, the trailing sync field starts, and an end-of-block flag is raised. The flag stays high until the host acknowledges the end of the record.

Top module: `pe_tape_fmt`

## Requirements
- R1: While reset is held and after it is released, `tr_vld`, `eob` and `wd_ready` are low.
- R2: `cfg_load` in idle stores `cfg_count` as the frame count. Nothing is emitted until `wclk_go` is sampled high in idle. The first half-cell appears on the second rising edge after that sample.
- R3: The record opens with 40 characters that have all nine tracks zero, followed by one character that has all nine tracks one.
- R4: Each 16-bit word gives its bits 7:0 first and its bits 15:8 second. `wd_ready` is high only at the start of a word's first character, so exactly ceil(N/2) words are accepted. With an odd N the high byte of the last word is dropped. No half-cells are emitted while a requested word is missing, and none are lost. When words are always offered, the output has no gaps.
- R5: On a data character, tracks 7:0 carry the data byte and track 8 carries odd parity, so that the nine bits hold an odd number of ones.
- R6: Each character is sent as two consecutive half-cells, with `tr_half` 0 and then 1. A 1 bit gives a low level and then a high level. A 0 bit gives a high level and then a low level.
- R7: With 2^16 - N loaded (0 for N = 0), the record carries exactly N data characters. The total output is 2*(82+N) half-cells.
- R8: After the data, the block sends one all-ones character and then 40 all-zeros characters, then returns to idle and emits nothing more.
- R9: `eob` rises on the edge that presents the second half-cell of the last character before the trailing field. It stays high until `eor_ack` is sampled high, and it is low after that edge.
- R10: `wclk_go` and `cfg_load` are ignored while a record is being written. The output stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Store `cfg_count` as frame count (idle only) |
| cfg_count | input | 16 | Negated character count |
| wclk_go | input | 1 | Drive up to speed; starts the record (idle only) |
| wd_valid | input | 1 | Host word valid |
| wd_data | input | 16 | Host word |
| wd_ready | output | 1 | Block takes the offered word this cycle |
| eor_ack | input | 1 | End-of-record acknowledge, clears `eob` |
| tr_vld | output | 1 | A half-cell is present on `tr_level` |
| tr_half | output | 1 | 0 for the first half-cell, 1 for the second |
| tr_level | output | 9 | Track levels; track 8 is parity |
| eob | output | 1 | End-of-block flag |

## Verification
The first half-cell is due two rising edges after `wclk_go` is sampled. After that, each half-cell appears one edge after the sequencer steps. The bench therefore checks the start against that exact count of edges and compares every `tr_vld` cycle, in order, with a queue built from the requirements. This also holds when the host inserts stalls. `eob` is checked at the half-cell two positions before the trailing field, where it must still be low, and at the next two half-cells, where it must be high. Its clearing is checked one edge after `eor_ack`. All outputs are sampled at the falling edge, so registered values are settled when they are read.

// File: rtl/pe_fmt_pkg.sv
package pe_fmt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_POST
  } fmt_state_e;

  typedef enum logic [1:0] {
    K_ZERO,
    K_ONES,
    K_DATA
  } char_kind_e;

endpackage

// File: rtl/pe_seq.sv
module pe_seq
  import pe_fmt_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CHAR_W    = 8,
  parameter int CNT_W     = 16,
  parameter int PRE_ZEROS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              wclk_go,
  input  logic              wd_valid,
  input  logic [WORD_W-1:0] wd_data,
  output logic              wd_ready,
  input  logic              eor_ack,
  output logic              emit,
  output logic              half,
  output char_kind_e        kind,
  output logic [CHAR_W-1:0] data_byte,
  output logic              eob
);

  localparam int CPW = WORD_W / CHAR_W;
  localparam int SW  = (CPW > 1) ? $clog2(CPW) : 1;
  localparam int PW  = $clog2(PRE_ZEROS + 1);

  fmt_state_e        state_q, state_n;
  logic              half_q, half_n;
  logic [PW-1:0]     idx_q, idx_n;
  logic [SW-1:0]     sel_q, sel_n;
  logic [CNT_W-1:0]  fcnt_q, fcnt_n, fcnt_inc;
  logic [WORD_W-1:0] word_q, cur_word;
  logic              eob_q, eob_set;
  logic              at_word_start, take, char_end, idx_last;

  assign at_word_start = (sel_q == '0) && !half_q;
  assign wd_ready      = (state_q == ST_DATA) && at_word_start;
  assign take          = wd_ready && wd_valid;
  assign cur_word      = take ? wd_data : word_q;
  assign fcnt_inc      = fcnt_q + 1'b1;
  assign idx_last      = (idx_q == PW'(PRE_ZEROS));

  always_comb begin
    data_byte = '0;
    for (int k = 0; k < CPW; k++) begin
      if (sel_q == SW'(k)) data_byte = cur_word[k*CHAR_W +: CHAR_W];
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:  begin emit = 1'b1; kind = idx_last ? K_ONES : K_ZERO; end
      ST_POST: begin emit = 1'b1; kind = (idx_q == '0) ? K_ONES : K_ZERO; end
      ST_DATA: begin emit = at_word_start ? wd_valid : 1'b1; kind = K_DATA; end
      default: begin emit = 1'b0; kind = K_ZERO; end
    endcase
  end

  assign char_end = emit && half_q;
  assign half     = half_q;
  assign eob      = eob_q;

  always_comb begin
    state_n = state_q;
    half_n  = emit ? ~half_q : half_q;
    idx_n   = idx_q;
    sel_n   = sel_q;
    fcnt_n  = fcnt_q;
    eob_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cfg_load) fcnt_n = cfg_count;
        if (wclk_go) begin
          state_n = ST_PRE;
          half_n  = 1'b0;
          idx_n   = '0;
          sel_n   = '0;
        end
      end
      ST_PRE: begin
        if (char_end) begin
          if (idx_last) begin
            idx_n = '0;
            sel_n = '0;
            if (fcnt_q == '0) begin
              state_n = ST_POST;
              eob_set = 1'b1;
            end else begin
              state_n = ST_DATA;
            end
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (char_end) begin
          fcnt_n = fcnt_inc;
          if (fcnt_inc == '0) begin
            state_n = ST_POST;
            sel_n   = '0;
            idx_n   = '0;
            eob_set = 1'b1;
          end else begin
            sel_n = (sel_q == SW'(CPW - 1)) ? '0 : sel_q + 1'b1;
          end
        end
      end
      ST_POST: begin
        if (char_end) begin
          if (idx_last) begin
            state_n = ST_IDLE;
            idx_n   = '0;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      half_q  <= 1'b0;
      idx_q   <= '0;
      sel_q   <= '0;
      fcnt_q  <= '0;
      word_q  <= '0;
      eob_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      half_q  <= half_n;
      idx_q   <= idx_n;
      sel_q   <= sel_n;
      fcnt_q  <= fcnt_n;
      if (take) word_q <= wd_data;
      if (eob_set)      eob_q <= 1'b1;
      else if (eor_ack) eob_q <= 1'b0;
    end
  end

  AST_WORD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_ready && wd_valid) |=> !wd_ready) else $error("word requested twice"); // R4

  AST_EOB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eob && !eor_ack) |=> eob) else $error("eob dropped early"); // R9

  AST_EOB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eob) |-> $past(eor_ack)) else $error("eob fell without ack"); // R9

  AST_POST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POST) |-> (fcnt_q == '0)) else $error("postamble with count left"); // R7

endmodule

// File: rtl/pe_char.sv
module pe_char
  import pe_fmt_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  char_kind_e        kind,
  input  logic [CHAR_W-1:0] data_byte,
  output logic [CHAR_W:0]   ch
);

  logic par;

  assign par = ~(^data_byte);

  always_comb begin
    unique case (kind)
      K_ONES:  ch = '1;
      K_DATA:  ch = {par, data_byte};
      default: ch = '0;
    endcase
  end

  always_comb begin
    if (kind == K_DATA) begin
      AST_ODD_WEIGHT: assert ($countones(ch) % 2 == 1) else $error("even weight character"); // R5
    end
  end

endmodule

// File: rtl/pe_enc.sv
module pe_enc #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emit,
  input  logic          half,
  input  logic [TW-1:0] ch,
  output logic          tr_vld,
  output logic          tr_half,
  output logic [TW-1:0] tr_level
);

  logic [TW-1:0] level_n;

  assign level_n = half ? ch : ~ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tr_vld   <= 1'b0;
      tr_half  <= 1'b0;
      tr_level <= '0;
    end else begin
      tr_vld <= emit;
      if (emit) begin
        tr_half  <= half;
        tr_level <= level_n;
      end
    end
  end

  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_vld && !tr_half) |=> (tr_vld && tr_half)) else $error("half-cell pair broken"); // R6

  AST_MID_TRANSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_vld && tr_half) |-> (tr_level == ~$past(tr_level))) else $error("no mid-cell transition"); // R6

endmodule

// File: rtl/pe_tape_fmt.sv
module pe_tape_fmt
  import pe_fmt_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CHAR_W    = 8,
  parameter int CNT_W     = 16,
  parameter int PRE_ZEROS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              wclk_go,
  input  logic              wd_valid,
  input  logic [WORD_W-1:0] wd_data,
  output logic              wd_ready,
  input  logic              eor_ack,
  output logic              tr_vld,
  output logic              tr_half,
  output logic [CHAR_W:0]   tr_level,
  output logic              eob
);

  localparam int TW = CHAR_W + 1;

  logic              emit, half;
  char_kind_e        kind;
  logic [CHAR_W-1:0] data_byte;
  logic [TW-1:0]     ch;

  pe_seq #(
    .WORD_W(WORD_W), .CHAR_W(CHAR_W), .CNT_W(CNT_W), .PRE_ZEROS(PRE_ZEROS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_count(cfg_count),
    .wclk_go(wclk_go), .wd_valid(wd_valid), .wd_data(wd_data),
    .wd_ready(wd_ready), .eor_ack(eor_ack), .emit(emit), .half(half),
    .kind(kind), .data_byte(data_byte), .eob(eob)
  );

  pe_char #(.CHAR_W(CHAR_W)) u_char (
    .kind(kind), .data_byte(data_byte), .ch(ch)
  );

  pe_enc #(.TW(TW)) u_enc (
    .clk(clk), .rst_n(rst_n), .emit(emit), .half(half), .ch(ch),
    .tr_vld(tr_vld), .tr_half(tr_half), .tr_level(tr_level)
  );

endmodule

// File: tb/sim_pe_tape_fmt.sv
module sim_pe_tape_fmt;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_count = '0;
  logic        wclk_go = 1'b0;
  logic        wd_valid = 1'b0;
  logic [15:0] wd_data = '0;
  logic        wd_ready;
  logic        eor_ack = 1'b0;
  logic        tr_vld, tr_half, eob;
  logic [8:0]  tr_level;

  pe_tape_fmt u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_count(cfg_count),
    .wclk_go(wclk_go), .wd_valid(wd_valid), .wd_data(wd_data),
    .wd_ready(wd_ready), .eor_ack(eor_ack), .tr_vld(tr_vld),
    .tr_half(tr_half), .tr_level(tr_level), .eob(eob)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [9:0]  exp_q[$];
  logic [15:0] wq[$];
  int  pop_idx = 0, post_at = 0, n_data = 0, taken = 0, cyc = 0;
  int  first_cyc = -1, last_cyc = -1;
  bit  mon_on = 0, stall_mode = 0, take_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Host word feeder
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (take_flag && wq.size() > 0) begin
      void'(wq.pop_front());
      taken++;
    end
    if (wq.size() > 0 && !(stall_mode && (cyc % 3 == 1))) begin
      wd_valid = 1'b1;
      wd_data  = wq[0];
    end else begin
      wd_valid = 1'b0;
    end
    take_flag = wd_valid && wd_ready && rst_n;
  end

  // Per-clock comparison against the reference stream
  always @(negedge clk) begin
    if (rst_n && mon_on && tr_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 extra half-cell", {tr_half, tr_level}, 0);
      end else begin
        logic [9:0] e;
        string tag;
        e = exp_q.pop_front();
        if (pop_idx < 82) tag = "R3";
        else if (pop_idx < post_at) tag = "R5";
        else tag = "R8";
        chk({tr_half, tr_level} == e, tag, {tr_half, tr_level}, e);
        if (pop_idx == post_at - 2) chk(eob == 1'b0, "R9 early", eob, 0);
        if (pop_idx == post_at - 1) chk(eob == 1'b1, "R9 rise", eob, 1);
        if (pop_idx == post_at)     chk(eob == 1'b1, "R9 post", eob, 1);
        if (first_cyc < 0) first_cyc = cyc;
        last_cyc = cyc;
        pop_idx++;
      end
    end
  end

  task automatic push_char(input logic [8:0] c);
    exp_q.push_back({1'b0, ~c});
    exp_q.push_back({1'b1, c});
  endtask

  task automatic run_write(input int n, input bit stall, input bit disturb);
    int nw;
    nw = (n + 1) / 2;
    exp_q.delete();
    wq.delete();
    pop_idx = 0; post_at = 2 * (41 + n); n_data = n; taken = 0;
    first_cyc = -1; last_cyc = -1;
    stall_mode = stall;
    for (int i = 0; i < 40; i++) push_char(9'h000);
    push_char(9'h1FF);
    for (int k = 0; k < nw; k++) wq.push_back({8'(k * 37 + 5), 8'(k * 91)});
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      int ones;
      b = (i % 2) ? wq[i / 2][15:8] : wq[i / 2][7:0];
      ones = 0;
      for (int j = 0; j < 8; j++) ones += b[j];
      push_char({(ones % 2 == 0), b});
    end
    push_char(9'h1FF);
    for (int i = 0; i < 40; i++) push_char(9'h000);
    wq.push_back(16'hDEAD);
    wq.push_back(16'hBEEF);
    @(negedge clk);
    cfg_load = 1'b1; cfg_count = 16'(65536 - n);
    @(negedge clk);
    cfg_load = 1'b0;
    repeat (3) @(negedge clk);
    chk(tr_vld == 1'b0, "R2 before start", tr_vld, 0);
    chk(wd_ready == 1'b0, "R4 no request idle", wd_ready, 0);
    mon_on = 1;
    wclk_go = 1'b1;
    @(negedge clk);
    wclk_go = 1'b0;
    chk(tr_vld == 1'b0, "R2 one edge", tr_vld, 0);
    @(negedge clk);
    chk(tr_vld == 1'b1, "R2 two edges", tr_vld, 1);
    if (disturb) begin
      repeat (110) @(negedge clk);
      wclk_go = 1'b1; cfg_load = 1'b1; cfg_count = 16'hFFFD;
      @(negedge clk);
      wclk_go = 1'b0; cfg_load = 1'b0;
    end
    begin
      int t;
      t = 0;
      while (exp_q.size() != 0 && t < 3000) begin
        @(negedge clk);
        t++;
      end
      chk(exp_q.size() == 0, "R7 stream incomplete", exp_q.size(), 0);
    end
    repeat (4) @(negedge clk);
    chk(pop_idx == 2 * (82 + n), "R7 length", pop_idx, 2 * (82 + n));
    chk(taken == nw, "R4 words taken", taken, nw);
    if (!stall) chk(last_cyc - first_cyc + 1 == 2 * (82 + n), "R4 no gaps",
                    last_cyc - first_cyc + 1, 2 * (82 + n));
    chk(eob == 1'b1, "R9 held", eob, 1);
    repeat (10) @(negedge clk);
    chk(eob == 1'b1, "R9 held long", eob, 1);
    if (disturb) chk(tr_vld == 1'b0, "R10 no restart", tr_vld, 0);
    eor_ack = 1'b1;
    @(negedge clk);
    eor_ack = 1'b0;
    chk(eob == 1'b0, "R9 cleared", eob, 0);
    wq.delete();
    mon_on = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tr_vld == 1'b0 && eob == 1'b0 && wd_ready == 1'b0, "R1 in reset",
        {tr_vld, eob, wd_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tr_vld == 1'b0 && eob == 1'b0 && wd_ready == 1'b0, "R1 after reset",
        {tr_vld, eob, wd_ready}, 0);

    run_write(6, 1'b0, 1'b0);
    run_write(7, 1'b0, 1'b0);
    run_write(0, 1'b0, 1'b0);
    run_write(9, 1'b1, 1'b0);
    run_write(10, 1'b0, 1'b1);

    // Reset in the middle of a record
    wq.push_back(16'h1111);
    cfg_load = 1'b1; cfg_count = 16'(65536 - 20);
    @(negedge clk);
    cfg_load = 1'b0; wclk_go = 1'b1;
    @(negedge clk);
    wclk_go = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    wq.delete();
    @(negedge clk);
    chk(tr_vld == 1'b0 && eob == 1'b0 && wd_ready == 1'b0, "R1 mid reset",
        {tr_vld, eob, wd_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tr_vld == 1'b0, "R1 idle after reset", tr_vld, 0);
    run_write(2, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R2 watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule